// File: doc/BRIEF.md
# Serial ADC host controller

This block runs one conversion exchange with a two-channel serial analog-to-digital converter. The exchange uses four lines: an active-low select, a serial clock, a command line to the converter and a data line back from it. A pulse on `go` while the block is idle starts a transaction. The request carries a single-ended/differential flag, a channel/polarity bit and a mode flag. The controller pulls select low and derives the serial clock from the system clock through a parameterised divider. In the default mode it sends a five-bit command: a one, the mode flag, the channel bit and two zero acquisition bits. It then lets two null bits pass and shifts in the conversion result most significant bit first. It releases select, waits one full serial period with select high, and then presents the result with a one-cycle `done` strobe.

When `three_wire` is set at request time, the block sends no command. The first serial clock only wakes the converter's output. Two null bits follow, then the result. The serial clock idles low. The command line idles low, so the converter never sees a spurious leading one.

Top module: `sadc_host`

## Requirements
- R1: After reset, `adc_cs_n` is 1, `adc_sclk` is 0, `adc_mosi` is 0, `busy` is 0, `done` is 0 and `result` is 0.
- R2: When `go` is sampled high while `busy` is low, `adc_cs_n` falls and `busy` rises in the next cycle. The serial clock then toggles every HALF_DIV system clocks, and its first rising edge comes HALF_DIV cycles after select falls.
- R3: In command mode (`three_wire`=0), `adc_mosi` holds, in order across the first five serial rising edges: 1, `single_end`, `chan_odd`, 0, 0. The line changes only on the system edge that lowers the serial clock (or that lowers select), never on one that raises it.
- R4: `adc_mosi` is 0 whenever a command bit is not being presented, including the whole time select is high.
- R5: In command mode there are 8+RES_W serial rising edges. The data line is sampled at rising edges 9 through 8+RES_W, so the two null bits driven at edges 6 and 7 are discarded. The first bit sampled becomes `result[RES_W-1]`.
- R6: In three-wire mode there are 3+RES_W serial rising edges and no command bits. The result is sampled at edges 4 through 3+RES_W, again MSB first.
- R7: Select rises together with the last serial falling edge. Exactly 2*HALF_DIV system cycles later, `done` is high for one cycle, `busy` is low in that same cycle and `result` holds the captured value.
- R8: `go` is ignored while `busy` is high. Select does not fall again, and the command in flight is not altered.
- R9: `result` does not change while the block is idle.
- R10: `adc_sclk` is 0 whenever `adc_cs_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Request a transaction (taken when idle) |
| single_end | input | 1 | Single-ended (1) or differential (0) selection, sent as command bit 2 |
| chan_odd | input | 1 | Channel / polarity select, sent as command bit 3 |
| three_wire | input | 1 | 1: no command word, result only |
| busy | output | 1 | Transaction in progress, from select fall up to the done cycle |
| done | output | 1 | One-cycle strobe, result valid |
| result | output | RES_W | Captured conversion value |
| adc_cs_n | output | 1 | Active-low converter select |
| adc_sclk | output | 1 | Serial clock, idle low |
| adc_mosi | output | 1 | Command line to the converter |
| adc_miso | input | 1 | Data line from the converter |

## Verification
A behavioural converter model answers each transaction, and a cycle-count reference predicts every output. The bench walks all four mux codes with random result values and checks the command the model received, so a swapped or late command bit is reported. Varied result values expose a controller that keeps a null bit or drops the last bit: its result comes out shifted by one position. Three-wire transactions catch a design that still sends a command or counts command edges. A `go` pulse while busy, and `go` held high across the done cycle, catch a controller that restarts in mid-exchange or shortens the select-high recovery gap.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  // bits in the outgoing command: start, mode, channel, two acquisition bits
  localparam int CMD_BITS  = 5;
  // null bits the converter emits ahead of the result
  localparam int NULL_BITS = 2;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_GAP  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/sadc_tick.sv
// Half-period tick generator for the serial clock.
module sadc_tick #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] CNT_TOP = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_nx;

  always_comb begin
    tick   = run && (cnt_q == CNT_TOP);
    cnt_nx = cnt_q;
    if (!run)      cnt_nx = '0;
    else if (tick) cnt_nx = '0;
    else           cnt_nx = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nx;
  end
endmodule

// File: rtl/sadc_seq.sv
// Transaction sequencer: select, serial clock, edge counting, done.
module sadc_seq
  import sadc_pkg::*;
#(
  parameter int RES_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic go,
  input  logic three_wire,
  output logic run,
  output logic busy,
  output logic done,
  output logic cs_n,
  output logic sclk,
  output logic start_p,
  output logic fall_p,
  output logic sample_p
);
  localparam int EW = $clog2(CMD_BITS + NULL_BITS + RES_W + 2);
  localparam logic [EW-1:0] LAST_CMD = EW'(CMD_BITS + NULL_BITS + RES_W + 1);
  localparam logic [EW-1:0] LAST_3W  = EW'(NULL_BITS + RES_W + 1);
  localparam logic [EW-1:0] SMP_CMD  = EW'(CMD_BITS + NULL_BITS + 2);
  localparam logic [EW-1:0] SMP_3W   = EW'(NULL_BITS + 2);

  seq_state_t    st_q, st_nx;
  logic          sclk_q, sclk_nx;
  logic          cs_n_q, cs_n_nx;
  logic          done_q, done_nx;
  logic          tw_q, tw_nx;
  logic          gap_q, gap_nx;
  logic [EW-1:0] edg_q, edg_nx;
  logic [EW-1:0] edg_inc, last_edge, first_smp;

  always_comb begin
    edg_inc   = edg_q + EW'(1);
    last_edge = tw_q ? LAST_3W : LAST_CMD;
    first_smp = tw_q ? SMP_3W  : SMP_CMD;
    st_nx     = st_q;
    sclk_nx   = sclk_q;
    cs_n_nx   = cs_n_q;
    tw_nx     = tw_q;
    gap_nx    = gap_q;
    edg_nx    = edg_q;
    done_nx   = 1'b0;
    start_p   = 1'b0;
    fall_p    = 1'b0;
    sample_p  = 1'b0;
    unique case (st_q)
      SEQ_IDLE: if (go) begin
        st_nx   = SEQ_RUN;
        cs_n_nx = 1'b0;
        tw_nx   = three_wire;
        edg_nx  = '0;
        gap_nx  = 1'b0;
        start_p = 1'b1;
      end
      SEQ_RUN: if (tick) begin
        if (sclk_q) begin
          sclk_nx = 1'b0;
          fall_p  = 1'b1;
          if (edg_q == last_edge) begin
            st_nx   = SEQ_GAP;
            cs_n_nx = 1'b1;
          end
        end else begin
          sclk_nx  = 1'b1;
          edg_nx   = edg_inc;
          sample_p = (edg_inc >= first_smp);
        end
      end
      SEQ_GAP: if (tick) begin
        if (gap_q) begin
          st_nx   = SEQ_IDLE;
          done_nx = 1'b1;
        end else begin
          gap_nx = 1'b1;
        end
      end
      default: st_nx = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      sclk_q <= 1'b0;
      cs_n_q <= 1'b1;
      done_q <= 1'b0;
      tw_q   <= 1'b0;
      gap_q  <= 1'b0;
      edg_q  <= '0;
    end else begin
      st_q   <= st_nx;
      sclk_q <= sclk_nx;
      cs_n_q <= cs_n_nx;
      done_q <= done_nx;
      tw_q   <= tw_nx;
      gap_q  <= gap_nx;
      edg_q  <= edg_nx;
    end
  end

  assign run  = (st_q != SEQ_IDLE);
  assign busy = run;
  assign done = done_q;
  assign cs_n = cs_n_q;
  assign sclk = sclk_q;
endmodule

// File: rtl/sadc_shift.sv
// Command serialiser and result deserialiser.
module sadc_shift
  import sadc_pkg::*;
#(
  parameter int RES_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_p,
  input  logic             fall_p,
  input  logic             sample_p,
  input  logic             single_end,
  input  logic             chan_odd,
  input  logic             three_wire,
  input  logic             miso,
  output logic             mosi,
  output logic [RES_W-1:0] result
);
  logic [CMD_BITS-1:0] cmd_q, cmd_nx;
  logic [RES_W-1:0]    res_q, res_nx;

  always_comb begin
    cmd_nx = cmd_q;
    if (start_p)
      cmd_nx = three_wire ? '0
                          : {1'b1, single_end, chan_odd, {(CMD_BITS-3){1'b0}}};
    else if (fall_p)
      cmd_nx = {cmd_q[CMD_BITS-2:0], 1'b0};
    res_nx = sample_p ? {res_q[RES_W-2:0], miso} : res_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      res_q <= '0;
    end else begin
      cmd_q <= cmd_nx;
      res_q <= res_nx;
    end
  end

  assign mosi   = cmd_q[CMD_BITS-1];
  assign result = res_q;
endmodule

// File: rtl/sadc_host.sv
// Serial ADC host controller top.
module sadc_host #(
  parameter int RES_W    = 8,
  parameter int HALF_DIV = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             single_end,
  input  logic             chan_odd,
  input  logic             three_wire,
  output logic             busy,
  output logic             done,
  output logic [RES_W-1:0] result,
  output logic             adc_cs_n,
  output logic             adc_sclk,
  output logic             adc_mosi,
  input  logic             adc_miso
);
  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  logic       run, tick, start_p, fall_p, sample_p;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  sadc_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n_s), .run(run), .tick(tick)
  );

  sadc_seq #(.RES_W(RES_W)) u_seq (
    .clk(clk), .rst_n(rst_n_s), .tick(tick), .go(go),
    .three_wire(three_wire), .run(run), .busy(busy), .done(done),
    .cs_n(adc_cs_n), .sclk(adc_sclk), .start_p(start_p),
    .fall_p(fall_p), .sample_p(sample_p)
  );

  sadc_shift #(.RES_W(RES_W)) u_shift (
    .clk(clk), .rst_n(rst_n_s), .start_p(start_p), .fall_p(fall_p),
    .sample_p(sample_p), .single_end(single_end), .chan_odd(chan_odd),
    .three_wire(three_wire), .miso(adc_miso), .mosi(adc_mosi),
    .result(result)
  );
endmodule

// File: rtl/sadc_host_chk.sv
module sadc_host_chk #(
  parameter int RES_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic [RES_W-1:0] result,
  input logic             adc_cs_n,
  input logic             adc_sclk,
  input logic             adc_mosi
);
  // R10
  sclk_low_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cs_n |-> !adc_sclk);
  // R4
  mosi_quiet_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cs_n |-> !adc_mosi);
  // R3
  mosi_steady_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_sclk) |-> $stable(adc_mosi));
  // R2
  select_fall_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_cs_n) |-> busy);
  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && adc_cs_n);
  // R8
  no_restart_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !$fell(adc_cs_n));
  // R9
  result_hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> $stable(result));
endmodule

bind sadc_host sadc_host_chk #(.RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .result(result),
  .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .adc_mosi(adc_mosi)
);

// File: tb/sadc_host_test.sv
module sadc_host_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int H = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go = 1'b0, single_end = 1'b0, chan_odd = 1'b0, three_wire = 1'b0;
  logic busy, done, adc_cs_n, adc_sclk, adc_mosi;
  logic adc_miso = 1'b0;
  logic [N-1:0] result;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sadc_host #(.RES_W(N), .HALF_DIV(H)) uut (
    .clk(clk), .rst_n(rst_n), .go(go), .single_end(single_end),
    .chan_odd(chan_odd), .three_wire(three_wire), .busy(busy), .done(done),
    .result(result), .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk),
    .adc_mosi(adc_mosi), .adc_miso(adc_miso)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- converter model ----------------
  logic [N-1:0] dev_val = '0;
  bit           dev_tw = 1'b0;
  logic [4:0]   d_cmd = '0;
  int           d_cnt = 0;

  always @(posedge adc_sclk or posedge adc_cs_n) begin
    if (adc_cs_n) begin
      d_cnt = 0;
      adc_miso <= 1'b0;
    end else begin
      int j;
      d_cnt = d_cnt + 1;
      if (!dev_tw && d_cnt <= 5) d_cmd = {d_cmd[3:0], adc_mosi};
      j = d_cnt - (dev_tw ? 0 : 5) - 3;
      if (j >= 0 && j < N) adc_miso <= dev_val[N-1-j];
      else                 adc_miso <= 1'b0;
    end
  end

  // ---------------- cycle reference ----------------
  bit m_act = 0, m_tw = 0, m_sgl = 0, m_odd = 0, m_done = 0;
  int k = 0, e_tot = 0;
  logic [N-1:0] m_res = '0;

  always @(posedge clk) begin
    m_done = 1'b0;
    if (!rst_n) begin
      m_act = 1'b0;
      m_res = '0;
    end else if (m_act) begin
      k = k + 1;
      if (k == (2*e_tot + 2)*H) begin
        m_act  = 1'b0;
        m_done = 1'b1;
      end
    end else if (go) begin
      m_act = 1'b1;
      k     = 0;
      m_tw  = three_wire;
      m_sgl = single_end;
      m_odd = chan_odd;
      m_res = dev_val;
      e_tot = (three_wire ? 0 : 5) + 2 + N + 1;
    end
  end

  function automatic bit cmd_bit(input int idx);
    case (idx)
      0:       return 1'b1;
      1:       return m_sgl;
      2:       return m_odd;
      default: return 1'b0;
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      bit e_cs, e_sclk, e_mosi, e_busy;
      int m, f;
      if (m_act) begin
        m      = k / H;
        f      = m / 2;
        e_cs   = (m >= 2*e_tot);
        e_sclk = (m < 2*e_tot) && (m % 2 == 1);
        e_mosi = (!m_tw && f < 5) ? cmd_bit(f) : 1'b0;
        e_busy = 1'b1;
      end else begin
        e_cs = 1'b1; e_sclk = 1'b0; e_mosi = 1'b0; e_busy = 1'b0;
        chk(result === m_res, "R9 result held while idle", result, m_res);
      end
      chk(adc_cs_n === e_cs, "R2 select timing", adc_cs_n, e_cs);
      chk(adc_sclk === e_sclk, e_cs ? "R10 sclk idle" : "R2 sclk timing", adc_sclk, e_sclk);
      chk(adc_mosi === e_mosi,
          (m_act && !m_tw && !e_cs) ? "R3 command bit" : "R4 mosi quiet", adc_mosi, e_mosi);
      chk(busy === e_busy, "R8 busy window", busy, e_busy);
      chk(done === m_done, "R7 done strobe", done, m_done);
    end
  end

  // ---------------- stimulus ----------------
  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic finish_txn(input bit tw, input bit sgl, input bit odd, input logic [N-1:0] v);
    while (!done) @(negedge clk);
    chk(result === v, tw ? "R6 three-wire result" : "R5 result MSB first", result, v);
    chk(busy === 1'b0, "R7 busy low with done", busy, 0);
    if (!tw) chk(d_cmd === {1'b1, sgl, odd, 2'b00}, "R3 command received", d_cmd,
                 {1'b1, sgl, odd, 2'b00});
  endtask

  task automatic txn(input bit tw, input bit sgl, input bit odd, input logic [N-1:0] v);
    wait_idle();
    dev_val = v; dev_tw = tw;
    three_wire = tw; single_end = sgl; chan_odd = odd;
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    finish_txn(tw, sgl, odd, v);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R7 watchdog: done never arrived");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [N-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(adc_cs_n === 1'b1, "R1 reset cs", adc_cs_n, 1);
    chk(adc_sclk === 1'b0, "R1 reset sclk", adc_sclk, 0);
    chk(adc_mosi === 1'b0, "R1 reset mosi", adc_mosi, 0);
    chk({busy, done} === 2'b00, "R1 reset busy/done", {busy, done}, 0);
    chk(result === '0, "R1 reset result", result, 0);

    // all four mux codes, command mode (R3, R5)
    for (int c = 0; c < 4; c++) begin
      v = N'($urandom);
      txn(1'b0, c[1], c[0], v);
    end
    txn(1'b0, 1'b1, 1'b0, {N{1'b1}});
    txn(1'b0, 1'b0, 1'b1, {1'b1, {(N-1){1'b0}}});
    txn(1'b0, 1'b1, 1'b1, {{(N-1){1'b0}}, 1'b1});

    // three-wire mode (R6)
    for (int i = 0; i < 3; i++) begin
      v = N'($urandom);
      txn(1'b1, 1'b1, 1'b1, v);
    end
    txn(1'b1, 1'b0, 1'b0, {1'b1, {(N-2){1'b0}}, 1'b1});

    // R9 result held after done
    repeat (12) @(negedge clk);
    chk(result === {1'b1, {(N-2){1'b0}}, 1'b1}, "R9 result after idle wait", result,
        {1'b1, {(N-2){1'b0}}, 1'b1});

    // R8 go pulsed mid-transaction with other settings
    wait_idle();
    v = 8'h5A;
    dev_val = v; dev_tw = 1'b0;
    three_wire = 1'b0; single_end = 1'b1; chan_odd = 1'b0;
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    repeat (20) @(negedge clk);
    single_end = 1'b0; chan_odd = 1'b1; three_wire = 1'b1;
    go = 1'b1;
    repeat (3) @(negedge clk);
    go = 1'b0;
    finish_txn(1'b0, 1'b1, 1'b0, v);
    chk(d_cmd === 5'b11000, "R8 command unchanged by busy go", d_cmd, 5'b11000);

    // R7/R8 go held across done: restart only after the recovery gap
    wait_idle();
    v = 8'hC3;
    dev_val = v; dev_tw = 1'b0;
    three_wire = 1'b0; single_end = 1'b0; chan_odd = 1'b0;
    go = 1'b1;
    @(negedge clk);
    finish_txn(1'b0, 1'b0, 1'b0, v);
    @(negedge clk);
    go = 1'b0;
    finish_txn(1'b0, 1'b0, 1'b0, v);

    repeat (10) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule